// File: doc/BRIEF.md
# Pin Interrupt Detector Bank

This block watches a bank of general-purpose input pins and turns selected pin activity into a single interrupt request. Every pin has its own detector, which can be set to respond to an edge or to a level. A pending bit records each detected event and stays set until software acknowledges it. A per-pin mask decides whether a pending bit reaches the shared interrupt line. The mask only gates propagation. Detection and pending capture go on behind a mask, so an event that occurs while a pin is masked is still seen once the pin is unmasked.

Software reaches the block through a small word-wide register port. The port has a synchronous write strobe, an address and a combinational read. Several banks can sit side by side, because each one reports its lowest pending unmasked pin as a global index that includes its own bank base. Raw pin levels are brought into the clock domain through a two-stage synchronizer before any detection takes place.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, all pending bits read 0, all mask bits read 1, every pin is in level mode (type 0) with active-high polarity (polarity 1) and any-edge off, and irq_o is 0.
- R2: A pin change reaches detection through two synchronizer flops. A change driven before clock edge k sets the pending bit at edge k+2, so it is visible after that edge and not after edge k+1.
- R3: Type bit 1 selects edge detection for the pin, and type bit 0 selects level detection.
- R4: In edge mode with any-edge 0, polarity 1 detects only a rising edge and polarity 0 detects only a falling edge.
- R5: In edge mode with any-edge 1, both a rising and a falling edge set the pending bit, whatever the polarity.
- R6: In level mode, polarity 1 treats a high pin as active and polarity 0 treats a low pin as active.
- R7: A pending bit stays set until acknowledged, even after its condition goes away. Writing 1 to it while a level condition is still active leaves it set.
- R8: An edge condition lasts only for the cycle in which the edge is seen. An acknowledge at any later time clears the bit, and it stays clear until the next qualifying edge.
- R9: Acknowledge is write-1-to-clear on the status address (4). Bits written with 0 keep their value.
- R10: A mask bit of 1 blocks that pin from irq_o but does not stop detection. Unmasking a pin whose bit is already pending raises irq_o.
- R11: irq_o is 1 exactly when some pin is pending and unmasked.
- R12: If a new condition occurs in the same cycle as an acknowledge of that pin, the pending bit stays set.
- R13: While irq_o is 1, irq_id_o equals BANK_ID*NUM_PINS plus the lowest-numbered pending unmasked pin.
- R14: Register addresses are: 0 type, 1 polarity, 2 any-edge, 3 mask, 4 status. Addresses 0 to 3 read back the last value written, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Raw asynchronous pin levels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | NUM_PINS | Register write data |
| rdata_o | output | NUM_PINS | Register read data, combinational from addr_i |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | ID_W | Global index of the lowest pending unmasked pin |

## Verification
The assertions check several rules on every cycle. A pending bit may only fall after an acknowledge of that bit in a cycle with no active condition. Any active condition shows up as pending on the following edge. An edge-mode condition needs the synchronized sample to differ from the previous one. A fully masked or empty bank never raises irq_o, and a raised irq_o always carries an index inside this bank's range that points at a pending unmasked pin. Only the directed scenarios can show the rest: the exact synchronizer latency, the choice among polarity, edge and any-edge settings, the read-back map, and the timing of an acknowledge that collides with a fresh edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TYPE = 3'd0,
    REG_POL  = 3'd1,
    REG_ANY  = 3'd2,
    REG_MASK = 3'd3,
    REG_STAT = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] type_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] any_i,
  output logic [NUM_PINS-1:0] cond_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, edge_hit, level_hit;
    assign rise      = cur_i[i] & ~prev_q[i];
    assign fall      = ~cur_i[i] & prev_q[i];
    assign edge_hit  = any_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign level_hit = pol_i[i] ? cur_i[i] : ~cur_i[i];
    assign cond_o[i] = type_i[i] ? edge_hit : level_hit;
  end

  // R8: edge-mode condition only in a cycle where the sample changed
  p_edge_needs_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cond_o & type_i & ~(cur_i ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ID_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] cond_i,
  input  logic [NUM_PINS-1:0] ack_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o,
  output logic [ID_W-1:0]     irq_id_o
);
  localparam int unsigned BASE = BANK_ID * NUM_PINS;

  logic [NUM_PINS-1:0] status_q, live;

  // new condition wins over a simultaneous acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= cond_i | (status_q & ~ack_i);
  end

  assign live     = status_q & ~mask_i;
  assign irq_o    = |live;
  assign status_o = status_q;

  always_comb begin
    irq_id_o = ID_W'(BASE);
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (live[i]) irq_id_o = ID_W'(BASE + i);
    end
  end

  // R7: a bit falls only after an acknowledge with no active condition
  p_clear_needs_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_q) & ~status_q & ~($past(ack_i) & ~$past(cond_i))) == '0));

  // R12: any active condition is pending on the next edge
  p_cond_sets_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cond_i) |=> ((status_q & $past(cond_i)) == $past(cond_i)));

  // R13: reported index lies in this bank and names a live pin
  p_id_in_bank_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(irq_id_o) >= int'(BASE) && int'(irq_id_o) < int'(BASE + NUM_PINS)
               && live[int'(irq_id_o) - int'(BASE)]));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] status_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] type_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] any_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_o <= '0;
      pol_o  <= '1;
      any_o  <= '0;
      mask_o <= '1;
    end else if (we_i) begin
      case (addr_i)
        REG_TYPE: type_o <= wdata_i;
        REG_POL:  pol_o  <= wdata_i;
        REG_ANY:  any_o  <= wdata_i;
        REG_MASK: mask_o <= wdata_i;
        default: ;
      endcase
    end
  end

  assign ack_o = (we_i && addr_i == REG_STAT) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      REG_TYPE: rdata_o = type_o;
      REG_POL:  rdata_o = pol_o;
      REG_ANY:  rdata_o = any_o;
      REG_MASK: rdata_o = mask_o;
      REG_STAT: rdata_o = status_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned BANK_ID  = 0,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o,
  output logic [ID_W-1:0]     irq_id_o
);
  logic [NUM_PINS-1:0] pin_s, cond, status, ack;
  logic [NUM_PINS-1:0] type_r, pol_r, any_r, mask_r;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i, .rst_ni, .cur_i(pin_s), .type_i(type_r), .pol_i(pol_r),
    .any_i(any_r), .cond_o(cond)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .status_i(status),
    .rdata_o, .type_o(type_r), .pol_o(pol_r), .any_o(any_r),
    .mask_o(mask_r), .ack_o(ack)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS), .BANK_ID(BANK_ID), .ID_W(ID_W)) u_status (
    .clk_i, .rst_ni, .cond_i(cond), .ack_i(ack), .mask_i(mask_r),
    .status_o(status), .irq_o, .irq_id_o
  );

  // R10: fully masked bank never interrupts
  p_full_mask_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_r) |-> !irq_o);

  // R11: nothing pending means no interrupt
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == '0) |-> !irq_o);
endmodule

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  localparam int unsigned NP = 8;
  localparam int unsigned BK = 2;
  localparam int unsigned IW = 8;
  localparam int unsigned BASE = BK * NP;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic [NP-1:0] pins = '0;
  logic          we_i = 0;
  logic [2:0]    addr_i = '0;
  logic [NP-1:0] wdata_i = '0;
  logic [NP-1:0] rdata_o;
  logic          irq_o;
  logic [IW-1:0] irq_id_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  gpio_irq_bank #(.NUM_PINS(NP), .BANK_ID(BK), .ID_W(IW)) dut (
    .clk_i, .rst_ni, .pin_i(pins), .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .irq_id_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [NP-1:0] exp);
    addr_i = a;
    #1;
    check(req, int'(rdata_o), int'(exp));
  endtask

  task automatic t_reset;
    rd("R1 type", 3'd0, 8'h00);
    rd("R1 pol", 3'd1, 8'hFF);
    rd("R1 any", 3'd2, 8'h00);
    rd("R1 mask", 3'd3, 8'hFF);
    rd("R1 status", 3'd4, 8'h00);
    check("R1 irq", int'(irq_o), 0);
    rd("R14 unused addr", 3'd6, 8'h00);
  endtask

  task automatic t_regs;
    wr(3'd0, 8'hA5);
    rd("R14 type readback", 3'd0, 8'hA5);
    wr(3'd2, 8'h3C);
    rd("R14 any readback", 3'd2, 8'h3C);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    rd("R14 type restored", 3'd0, 8'h00);
  endtask

  task automatic t_level_high;
    wr(3'd3, 8'hFE);
    pins[0] = 1;
    wait_edges(2);
    rd("R2 not yet pending", 3'd4, 8'h00);
    wait_edges(1);
    rd("R2 R6 level high pending", 3'd4, 8'h01);
    check("R11 irq raised", int'(irq_o), 1);
    check("R13 id bank offset", int'(irq_id_o), BASE + 0);
    wr(3'd4, 8'h01);
    rd("R7 ack during active level", 3'd4, 8'h01);
    pins[0] = 0;
    wait_edges(3);
    rd("R7 sticky after level gone", 3'd4, 8'h01);
    wr(3'd4, 8'h01);
    rd("R7 ack clears", 3'd4, 8'h00);
    check("R11 irq dropped", int'(irq_o), 0);
  endtask

  task automatic t_level_low;
    wr(3'd1, 8'hFD);
    wait_edges(1);
    rd("R6 level low pending", 3'd4, 8'h02);
    check("R10 masked pin no irq", int'(irq_o), 0);
    pins[1] = 1;
    wait_edges(3);
    wr(3'd4, 8'h02);
    rd("R6 low level ack after high", 3'd4, 8'h00);
  endtask

  task automatic t_edge;
    wr(3'd0, 8'h04);
    pins[2] = 1;
    wait_edges(3);
    rd("R3 R4 rising edge", 3'd4, 8'h04);
    wr(3'd4, 8'h04);
    rd("R8 ack while pin held", 3'd4, 8'h00);
    wait_edges(4);
    rd("R8 stays clear", 3'd4, 8'h00);
    pins[2] = 0;
    wait_edges(3);
    rd("R4 falling ignored on rise pol", 3'd4, 8'h00);
    wr(3'd1, 8'hF9);
    pins[2] = 1;
    wait_edges(3);
    rd("R4 rising ignored on fall pol", 3'd4, 8'h00);
    pins[2] = 0;
    wait_edges(3);
    rd("R4 falling edge", 3'd4, 8'h04);
    wr(3'd4, 8'h04);
  endtask

  task automatic t_any;
    wr(3'd0, 8'h0C);
    wr(3'd2, 8'h08);
    pins[3] = 1;
    wait_edges(3);
    rd("R5 any rise", 3'd4, 8'h08);
    wr(3'd4, 8'h08);
    pins[3] = 0;
    wait_edges(3);
    rd("R5 any fall", 3'd4, 8'h08);
    wr(3'd4, 8'h08);
    rd("R5 cleared", 3'd4, 8'h00);
  endtask

  task automatic t_w1c;
    pins[2] = 1;
    wait_edges(3);
    pins[2] = 0;
    pins[3] = 1;
    wait_edges(3);
    rd("R9 two pending", 3'd4, 8'h0C);
    wr(3'd4, 8'h00);
    rd("R9 zero write keeps", 3'd4, 8'h0C);
    wr(3'd4, 8'h04);
    rd("R9 only written bit", 3'd4, 8'h08);
    wr(3'd4, 8'h08);
  endtask

  task automatic t_mask;
    wr(3'd0, 8'h1C);
    wr(3'd3, 8'hFF);
    pins[4] = 1;
    wait_edges(3);
    rd("R10 detect while masked", 3'd4, 8'h10);
    check("R10 masked quiet", int'(irq_o), 0);
    wr(3'd3, 8'hEF);
    check("R10 unmask raises", int'(irq_o), 1);
    check("R13 id pin4", int'(irq_id_o), BASE + 4);
    pins[3] = 0;
    wait_edges(3);
    wr(3'd3, 8'hE7);
    check("R13 lowest pin wins", int'(irq_id_o), BASE + 3);
    wr(3'd3, 8'hFF);
    check("R11 all masked", int'(irq_o), 0);
    wr(3'd4, 8'h18);
    rd("R11 cleared", 3'd4, 8'h00);
  endtask

  task automatic t_collision;
    wr(3'd0, 8'h3C);
    wr(3'd2, 8'h28);
    pins[5] = 1;
    wait_edges(3);
    rd("R12 set", 3'd4, 8'h20);
    pins[5] = 0;
    wait_edges(2);
    wr(3'd4, 8'h20);
    rd("R12 new edge beats ack", 3'd4, 8'h20);
    wr(3'd4, 8'h20);
    rd("R12 later ack clears", 3'd4, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    wait_edges(1);
    t_reset();
    t_regs();
    t_level_high();
    t_level_low();
    t_edge();
    t_any();
    t_w1c();
    t_mask();
    t_collision();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule